// File: doc/BRIEF.md
# Multi-Channel Successive-Approximation Scan Controller

This block is the digital side of an eight-input successive-approximation converter in a microcontroller. Software reaches it through a small byte-wide register bus. Through that bus it sets a clock divider, picks the channels to convert and starts a scan. A scan can also be started by a chosen edge on an external trigger pin, and that edge also gives a capture pulse. The block selects each enabled channel on the analog multiplexer in turn. For each channel it runs a ten-step binary search: it drives a trial code into the DAC and reads back one comparator bit per step. The result goes into a latch for that channel.

A scan runs once or repeats without end. When a scan is busy, more start requests have no effect. Clearing the start bit stops the scan at once. Each finished pass over the selected channels sets a sticky interrupt flag. Software can clear the flag but cannot set it. The multiplexer, DAC and comparator are outside the block.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset, the control register (address 0), the channel-select register (address 1) and every result read 0, and `irq` and `capture` are low. A zero prescale field selects divide by 2.
- R2: The prescale field, control bits 7:6, sets one search step every D clocks, where D is 2, 4, 6 or 8 for codes 0 to 3. A one-shot scan of N selected channels started at clock edge E clears the busy bit at edge E + 10·N·D.
- R3: Control bit 5 is reserved. It always reads 0, whatever value is written to it.
- R4: Each result is the 10-bit code found by the MSB-first search, in which a trial bit is kept when `comp_in` is 1. Address 16+2c returns bits 9:2 of the result for channel c. Address 17+2c returns bits 1:0 of that result in bits 1:0, with the upper bits zero.
- R5: Channels are converted in ascending order, where a 1 in bit c of address 1 selects channel c. The result of an unselected channel stays unchanged.
- R6: With the continuous bit (control bit 1) at 0, the busy/start bit (control bit 0) clears when the last selected channel finishes. The flag (control bit 4) is set on the same edge.
- R7: With the continuous bit at 1, the busy bit stays 1 and the scan restarts at once. The flag is set again at the end of every pass, and later passes refresh the results.
- R8: While busy, a software write of 1 to the start bit and a qualified trigger edge do not restart or change the timing of the scan in progress.
- R9: A software write of 0 to the start bit while busy aborts the scan on that edge. The flag is not set, and the channel that was being converted keeps its old result.
- R10: `ext_trig` passes through a two-flop synchronizer. A rising edge with control bit 2 set, or a falling edge with control bit 3 set, gives a one-cycle `capture` pulse two clocks after the pin changes. If the block is idle, the busy bit sets on the following edge. An edge whose enable bit is 0 does nothing.
- R11: Writing 0 to the flag bit clears the flag. Writing 1 to it leaves the flag unchanged. `irq` is the flag ANDed with `irq_en`.
- R12: A start request while the channel-select register is 0 leaves the busy bit at 0 and sets the flag on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on the address |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |
| ext_trig | input | 1 | External start trigger, asynchronous |
| capture | output | 1 | One-cycle pulse on a qualified trigger edge |
| mux_sel | output | 3 | Channel being converted |
| dac_code | output | 10 | Trial code sent to the DAC |
| comp_in | input | 1 | Comparator: 1 when the analog input is at or above the DAC level |

## Verification
A software start takes effect on its write edge. The bench keeps a free-running cycle count and records that edge. It then polls the busy bit and flag at falling edges, so a scan's length can be compared with exactly 10·N·D, and a second pass's flag with twice that. Abort and empty-selection results are due on the write edge itself, so they are read at the very next falling edge. For trigger starts, `capture` is sampled at the second falling edge after the pin changes and the busy bit at the third. Results are read only after the busy bit has cleared or the flag has risen.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
   // Control register bit positions
   localparam int B_START  = 0;
   localparam int B_CONT   = 1;
   localparam int B_RISE   = 2;
   localparam int B_FALL   = 3;
   localparam int B_FLAG   = 4;
   localparam int B_RSVD   = 5;
   localparam int B_PRE_LO = 6;

   // Register addresses
   localparam int A_CTRL     = 0;
   localparam int A_CHSEL    = 1;
   localparam int A_RES_BASE = 16;
endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
   parameter int PRE_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [PRE_W-1:0] sel,
   output logic             tick
);
   localparam int CNT_W = PRE_W + 1;

   generate
      if (PRE_W < 1) begin : g_bad_pre
         $error("adc_prescaler: PRE_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;

   // divide ratio 2*(sel+1): terminal count 2*sel+1
   assign limit = {sel, 1'b1};
   assign tick  = en && (cnt_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!en)    cnt_q <= '0;
      else if (tick)   cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end

   p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_in,
   output logic rise,
   output logic fall
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("adc_trig_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sh_q;
   logic                   prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         prev_q <= 1'b0;
      end else begin
         sh_q   <= {sh_q[SYNC_STAGES-2:0], trig_in};
         prev_q <= sh_q[SYNC_STAGES-1];
      end
   end

   assign rise = sh_q[SYNC_STAGES-1] & ~prev_q;
   assign fall = ~sh_q[SYNC_STAGES-1] & prev_q;

   p_rise_from_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rise |-> $past(trig_in, SYNC_STAGES));
endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq #(
   parameter int NCH   = 8,
   parameter int RES_W = 10
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     go,
   input  logic                     run,
   input  logic                     tick,
   input  logic                     comp,
   input  logic [NCH-1:0]           chsel,
   output logic [$clog2(NCH)-1:0]   ch,
   output logic [RES_W-1:0]         dac,
   output logic                     res_we,
   output logic [RES_W-1:0]         res_data,
   output logic                     pass_done
);
   localparam int CH_W  = $clog2(NCH);
   localparam int BIT_W = $clog2(RES_W);
   localparam logic [RES_W-1:0] MSB_CODE = RES_W'(1) << (RES_W - 1);
   localparam logic [BIT_W-1:0] TOP_BIT  = BIT_W'(RES_W - 1);

   // lowest selected channel at or above index lo; top bit flags a hit
   function automatic logic [CH_W:0] pick(input logic [NCH-1:0] sel, input int lo);
      logic [CH_W:0] r;
      r = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (sel[i] && i >= lo) r = {1'b1, CH_W'(i)};
      end
      return r;
   endfunction

   logic [CH_W-1:0]  ch_q;
   logic [BIT_W-1:0] bit_q;
   logic [RES_W-1:0] code_q;
   logic [RES_W-1:0] trial, kept;
   logic [CH_W:0]    first_hit, next_hit;
   logic             step, last;

   assign trial     = RES_W'(1) << bit_q;
   assign kept      = comp ? code_q : (code_q & ~trial);
   assign last      = (bit_q == '0);
   assign step      = run && tick;
   assign first_hit = pick(chsel, 0);
   assign next_hit  = pick(chsel, int'(ch_q) + 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ch_q   <= '0;
         bit_q  <= TOP_BIT;
         code_q <= MSB_CODE;
      end else if (go) begin
         ch_q   <= first_hit[CH_W-1:0];
         bit_q  <= TOP_BIT;
         code_q <= MSB_CODE;
      end else if (step) begin
         if (!last) begin
            code_q <= kept | (trial >> 1);
            bit_q  <= bit_q - 1'b1;
         end else begin
            ch_q   <= next_hit[CH_W] ? next_hit[CH_W-1:0] : first_hit[CH_W-1:0];
            bit_q  <= TOP_BIT;
            code_q <= MSB_CODE;
         end
      end
   end

   assign ch        = ch_q;
   assign dac       = code_q;
   assign res_we    = step && last;
   assign res_data  = kept;
   assign pass_done = res_we && !next_hit[CH_W];

   p_bit_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (int'(bit_q) < RES_W));
   p_ascend_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (res_we && !pass_done) |=> (ch_q > $past(ch_q)));
   p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> $stable(code_q));
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
   parameter int NCH   = 8,
   parameter int RES_W = 10
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [$clog2(NCH)-1:0] wr_ch,
   input  logic [RES_W-1:0]       wr_data,
   input  logic [$clog2(NCH)-1:0] rd_ch,
   output logic [RES_W-1:0]       rd_data
);
   localparam int CH_W = $clog2(NCH);

   logic [NCH-1:0][RES_W-1:0] latch_flat;

   generate
      for (genvar g = 0; g < NCH; g++) begin : g_ch
         logic [RES_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              q <= '0;
            else if (we && (wr_ch == CH_W'(g)))      q <= wr_data;
         end
         assign latch_flat[g] = q;
      end
   endgenerate

   assign rd_data = latch_flat[rd_ch];
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl #(
   parameter int NCH         = 8,
   parameter int RES_W       = 10,
   parameter int PRE_W       = 2,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 5
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_wr,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [7:0]             bus_wdata,
   output logic [7:0]             bus_rdata,
   input  logic                   irq_en,
   output logic                   irq,
   input  logic                   ext_trig,
   output logic                   capture,
   output logic [$clog2(NCH)-1:0] mux_sel,
   output logic [RES_W-1:0]       dac_code,
   input  logic                   comp_in
);
   import adc_scan_pkg::*;

   localparam int CH_W = $clog2(NCH);
   localparam int LO_W = RES_W - 8;

   generate
      if (NCH < 2 || NCH > 8) begin : g_bad_nch
         $error("adc_scan_ctrl: NCH must be 2..8");
      end
      if (RES_W < 9 || RES_W > 16) begin : g_bad_res
         $error("adc_scan_ctrl: RES_W must be 9..16");
      end
      if (PRE_W < 1 || PRE_W > 2) begin : g_bad_pre
         $error("adc_scan_ctrl: PRE_W must be 1..2");
      end
      if ((2 ** ADDR_W) < (A_RES_BASE + 2 * NCH)) begin : g_bad_addr
         $error("adc_scan_ctrl: ADDR_W too small for result window");
      end
   endgenerate

   logic             busy, cont, rise_en, fall_en, flag;
   logic [PRE_W-1:0] pre;
   logic [NCH-1:0]   chsel;
   logic             ctrl_wr, chsel_wr;
   logic             tick, rise, fall;
   logic             start_req, empty, go, abort, finish, flag_set;
   logic             res_we, pass_done;
   logic [RES_W-1:0] res_data, rd_res;
   logic [CH_W-1:0]  res_idx;

   assign ctrl_wr  = bus_wr && (int'(bus_addr) == A_CTRL);
   assign chsel_wr = bus_wr && (int'(bus_addr) == A_CHSEL);

   adc_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .en(busy), .sel(pre), .tick(tick));

   adc_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
      .clk(clk), .rst_n(rst_n), .trig_in(ext_trig), .rise(rise), .fall(fall));

   assign capture   = (rise && rise_en) || (fall && fall_en);
   assign start_req = (ctrl_wr && bus_wdata[B_START]) || capture;
   assign empty     = ~|chsel;
   assign go        = !busy && start_req && !empty;
   assign abort     = ctrl_wr && busy && !bus_wdata[B_START];
   assign finish    = busy && pass_done && (!cont || empty);
   assign flag_set  = (busy && pass_done && !abort) || (!busy && start_req && empty);

   adc_sar_seq #(.NCH(NCH), .RES_W(RES_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .go(go), .run(busy), .tick(tick), .comp(comp_in),
      .chsel(chsel), .ch(mux_sel), .dac(dac_code), .res_we(res_we),
      .res_data(res_data), .pass_done(pass_done));

   adc_result_bank #(.NCH(NCH), .RES_W(RES_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(res_we && !abort), .wr_ch(mux_sel),
      .wr_data(res_data), .rd_ch(res_idx), .rd_data(rd_res));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         cont    <= 1'b0;
         rise_en <= 1'b0;
         fall_en <= 1'b0;
         flag    <= 1'b0;
         pre     <= '0;
         chsel   <= '0;
      end else begin
         if (go)                  busy <= 1'b1;
         else if (abort || finish) busy <= 1'b0;

         if (flag_set)                              flag <= 1'b1;
         else if (ctrl_wr && !bus_wdata[B_FLAG])    flag <= 1'b0;

         if (ctrl_wr) begin
            cont    <= bus_wdata[B_CONT];
            rise_en <= bus_wdata[B_RISE];
            fall_en <= bus_wdata[B_FALL];
            pre     <= bus_wdata[B_PRE_LO +: PRE_W];
         end
         if (chsel_wr) chsel <= bus_wdata[NCH-1:0];
      end
   end

   assign irq = flag && irq_en;

   always_comb begin
      bus_rdata = '0;
      res_idx   = '0;
      if (int'(bus_addr) == A_CTRL) begin
         bus_rdata[B_START]          = busy;
         bus_rdata[B_CONT]           = cont;
         bus_rdata[B_RISE]           = rise_en;
         bus_rdata[B_FALL]           = fall_en;
         bus_rdata[B_FLAG]           = flag;
         bus_rdata[B_PRE_LO +: PRE_W] = pre;
      end else if (int'(bus_addr) == A_CHSEL) begin
         bus_rdata = 8'(chsel);
      end else if (int'(bus_addr) >= A_RES_BASE && int'(bus_addr) < A_RES_BASE + 2 * NCH) begin
         res_idx = CH_W'((int'(bus_addr) - A_RES_BASE) >> 1);
         if (bus_addr[0]) bus_rdata = 8'(rd_res[LO_W-1:0]);
         else             bus_rdata = rd_res[RES_W-1 -: 8];
      end
   end

   p_rsvd_no_effect_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && bus_wdata[B_RSVD] && !bus_wdata[B_START] && !busy) |=> !busy);
   p_oneshot_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && pass_done && !cont && !ctrl_wr) |=> (!busy && flag));
   p_cont_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && pass_done && cont && !empty && !ctrl_wr && !chsel_wr) |=> (busy && flag));
   p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && busy && !bus_wdata[B_START]) |=> !busy);
   p_trig_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && !busy && !ctrl_wr && !empty) |=> busy);
   p_no_sw_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !flag && !busy && !start_req) |=> !flag);
   p_empty_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && !busy && empty) |=> (!busy && flag));
endmodule

// File: tb/tb_adc_scan_ctrl.sv
`timescale 1ns/1ps
module tb_adc_scan_ctrl;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       bus_wr;
   logic [4:0] bus_addr;
   logic [7:0] bus_wdata;
   logic [7:0] bus_rdata;
   logic       irq_en, irq, ext_trig, capture, comp_in;
   logic [2:0] mux_sel;
   logic [9:0] dac_code;

   logic [9:0] analog  [8];
   logic [9:0] exp_res [8];
   int checks = 0, errors = 0, cyc = 0, last_edge = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   adc_scan_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_en(irq_en), .irq(irq),
      .ext_trig(ext_trig), .capture(capture), .mux_sel(mux_sel),
      .dac_code(dac_code), .comp_in(comp_in));

   assign comp_in = (analog[mux_sel] >= dac_code);

   // {chsel, prescale, base level, step per channel}
   localparam logic [29:0] VEC [5] = '{
      {8'h01, 2'd0, 10'd1023, 10'd0},
      {8'h81, 2'd1, 10'd0,    10'd146},
      {8'h5A, 2'd2, 10'd37,   10'd111},
      {8'hFF, 2'd3, 10'd512,  10'd77},
      {8'h24, 2'd0, 10'd511,  10'd1}
   };

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      bus_addr  = 5'(a);
      bus_wdata = 8'(d);
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
      last_edge = cyc;
   endtask

   task automatic rd(input int a, output int v);
      bus_addr = 5'(a);
      #0.1;
      v = int'(bus_rdata);
   endtask

   task automatic ctrl_bit(input int b, output int v);
      int r;
      rd(0, r);
      v = (r >> b) & 1;
   endtask

   // polls a control bit until it has the given value; returns the cycle stamp
   task automatic wait_ctrl(input int b, input int val, output int stamp);
      int v;
      for (int i = 0; i < 5000; i++) begin
         ctrl_bit(b, v);
         if (v == val) break;
         @(negedge clk);
      end
      stamp = cyc;
   endtask

   task automatic check_results(input string tag);
      int h, l;
      for (int c = 0; c < 8; c++) begin
         rd(16 + 2 * c, h);
         rd(17 + 2 * c, l);
         chk(tag, h, int'(exp_res[c]) >> 2);
         chk(tag, l, int'(exp_res[c]) & 3);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int v, t0, t1, n, cap_seen;
      rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
      irq_en = 1'b0; ext_trig = 1'b0;
      for (int c = 0; c < 8; c++) begin
         analog[c] = '0;
         exp_res[c] = '0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(0, v);  chk("R1 ctrl", v, 0);
      rd(1, v);  chk("R1 chsel", v, 0);
      chk("R1 irq", int'(irq), 0);
      chk("R1 capture", int'(capture), 0);
      check_results("R1 results");

      // R3 reserved bit reads zero
      wr(0, 8'hE0);
      rd(0, v);  chk("R3 reserved", v, 8'hC0);
      wr(0, 0);

      // R2 R4 R5 R6 table of scans
      for (int k = 0; k < 5; k++) begin
         logic [7:0] sel;
         logic [1:0] p;
         logic [9:0] base, stp;
         {sel, p, base, stp} = VEC[k];
         n = 0;
         for (int c = 0; c < 8; c++) begin
            analog[c] = 10'(int'(base) + int'(stp) * c);
            if (sel[c]) begin
               exp_res[c] = analog[c];
               n++;
            end
         end
         wr(1, int'(sel));
         wr(0, (int'(p) << 6) | 1);
         t0 = last_edge;
         wait_ctrl(0, 0, t1);
         chk("R2 scan length", t1 - t0, 10 * n * 2 * (int'(p) + 1));
         ctrl_bit(4, v);  chk("R6 flag after one-shot", v, 1);
         check_results("R4 R5 results");
      end

      // R11 flag clear-only and irq gating
      irq_en = 1'b1; #0.1;
      chk("R11 irq on", int'(irq), 1);
      irq_en = 1'b0; #0.1;
      chk("R11 irq masked", int'(irq), 0);
      irq_en = 1'b1;
      wr(0, 8'h10);
      ctrl_bit(4, v);  chk("R11 write 1 keeps flag", v, 1);
      wr(0, 0);
      ctrl_bit(4, v);  chk("R11 write 0 clears", v, 0);
      chk("R11 irq cleared", int'(irq), 0);
      wr(0, 8'h10);
      ctrl_bit(4, v);  chk("R11 software cannot set", v, 0);

      // R12 empty selection
      wr(1, 0);
      wr(0, 1);
      ctrl_bit(0, v);  chk("R12 busy stays 0", v, 0);
      ctrl_bit(4, v);  chk("R12 flag set", v, 1);
      wr(0, 0);

      // R8 restarts ignored while busy
      wr(1, 8'h01);
      analog[0] = 10'd700;
      wr(0, 8'hC5);
      t0 = last_edge;
      repeat (10) @(negedge clk);
      wr(0, 8'hC5);
      ext_trig = 1'b1;
      cap_seen = 0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         if (capture) cap_seen = 1;
      end
      chk("R10 pulse while busy", cap_seen, 1);
      wait_ctrl(0, 0, t1);
      chk("R8 timing unchanged", t1 - t0, 80);
      exp_res[0] = 10'd700;
      check_results("R8 results");

      // R10 trigger edges
      wr(0, 8'h04);
      analog[0] = 10'd321;
      ext_trig = 1'b0;
      cap_seen = 0;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         if (capture) cap_seen = 1;
      end
      chk("R10 disabled fall no pulse", cap_seen, 0);
      ctrl_bit(0, v);  chk("R10 disabled fall no start", v, 0);
      ext_trig = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R10 rise pulse", int'(capture), 1);
      ctrl_bit(0, v);  chk("R10 not yet busy", v, 0);
      @(negedge clk);
      chk("R10 pulse one cycle", int'(capture), 0);
      ctrl_bit(0, v);  chk("R10 rise starts", v, 1);
      t0 = cyc;
      wait_ctrl(0, 0, t1);
      chk("R10 trigger scan length", t1 - t0, 20);
      exp_res[0] = 10'd321;
      check_results("R10 rise result");

      wr(0, 8'h08);
      analog[0] = 10'd5;
      ext_trig = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R10 fall pulse", int'(capture), 1);
      @(negedge clk);
      ctrl_bit(0, v);  chk("R10 fall starts", v, 1);
      wait_ctrl(0, 0, t1);
      exp_res[0] = 10'd5;
      check_results("R10 fall result");
      ext_trig = 1'b1;
      cap_seen = 0;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         if (capture) cap_seen = 1;
      end
      chk("R10 disabled rise no pulse", cap_seen, 0);
      ctrl_bit(0, v);  chk("R10 disabled rise no start", v, 0);

      // R9 abort
      wr(0, 0);
      wr(1, 8'h03);
      analog[0] = 10'd111;
      analog[1] = 10'd222;
      wr(0, 1);
      repeat (25) @(negedge clk);
      wr(0, 0);
      ctrl_bit(0, v);  chk("R9 busy cleared", v, 0);
      repeat (30) @(negedge clk);
      ctrl_bit(4, v);  chk("R9 no flag", v, 0);
      exp_res[0] = 10'd111;
      check_results("R9 results");

      // R7 continuous
      wr(1, 8'h04);
      analog[2] = 10'd600;
      wr(0, 8'h03);
      t0 = last_edge;
      wait_ctrl(4, 1, t1);
      chk("R7 first pass", t1 - t0, 20);
      analog[2] = 10'd77;
      ctrl_bit(0, v);  chk("R7 busy stays", v, 1);
      wr(0, 8'h03);
      ctrl_bit(4, v);  chk("R7 flag cleared", v, 0);
      wait_ctrl(4, 1, t1);
      chk("R7 second pass", t1 - t0, 40);
      ctrl_bit(0, v);  chk("R7 still busy", v, 1);
      exp_res[2] = 10'd77;
      check_results("R7 results");
      wr(0, 8'h02);
      ctrl_bit(0, v);  chk("R9 abort continuous", v, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule